// File: doc/BRIEF.md
# System Clock Mode Controller

This block decides which oscillator clocks the CPU and the peripherals of a small microcontroller, and which clock enables and oscillator enables are active at any moment. Software writes a small control register to pick the clock source (fast main oscillator or slow subclock), the speed gear applied to the main clock, and the length of the oscillator stabilization wait. A read-only monitor bit in the readback shows which source is actually in use.

Moving to the subclock takes effect at once, and the main oscillator is then powered down. Moving back to the main clock turns the main oscillator on, but the system keeps running from the subclock until a countdown of subclock ticks has expired. Only then does the monitor bit switch. Every reset starts the block with the main clock selected, and it always passes through this stabilization wait first. Standby requests put the block into a sleep, stop or watch state. Which of these states is reached depends on the source that is active, and a wake pulse brings the block back. Oscillators are modelled only as enable outputs. The countdown is advanced by a subclock tick input.

Top module: `sysclk_mode_ctrl`

## Requirements
- R1: After reset the readback is 8'h01: bit 0 (source select, 1 = main) is 1, bits 2:1 (gear) are 00, bits 4:3 (wait select) are 00, bit 7 (monitor, 1 = main active) is 0, and bits 6:5 are 0. The main and sub oscillator enables and the CPU clock enable are 1.
- R2: A register write loads write-data bit 0 into the source select and bits 2:1 into the gear field at any time. The gear_sel output always equals the gear field.
- R3: A write that clears the source select while the main clock is active shows in the readback one cycle after the write. The monitor bit falls one cycle later. At that same edge the main oscillator enable drops.
- R4: A write that sets the source select while on the subclock raises the main oscillator enable one cycle after the select bit changes. The monitor stays 0 and the CPU keeps its clock during the wait.
- R5: The stabilization wait lasts 4096 sub_tick pulses for wait select 00 or 01, 16384 for 10, and 65536 for 11. The monitor rises at the edge that takes in the last tick. Cycles without sub_tick do not count.
- R6: Write-data bits 4:3 load the wait select field only while the monitor reads 1. Otherwise they are ignored.
- R7: With the main clock active, a standby request of kind 00 or 11 enters main-sleep and a request of kind 01 or 10 enters main-stop. Main-sleep gates only the CPU clock. Main-stop also gates the peripheral clock and the main oscillator.
- R8: With the subclock active, a standby request of kind 00 or 11 enters sub-sleep, kind 01 enters sub-stop and kind 10 enters watch. Sub-sleep gates only the CPU clock. Sub-stop gates both clocks and the sub oscillator. Watch gates both clocks and keeps the sub oscillator running.
- R9: A wake pulse returns any sleep, sub-stop or watch state to its run state on the next edge. Waking from main-stop instead enters the stabilization wait with the monitor at 0, and the full selected wait length applies.
- R10: The timebase enable is 1 only in main-run and main-sleep. It is 0 on the subclock, during the wait and in every stop or watch state.
- R11: Clearing the source select during a stabilization wait abandons the wait. The block returns to subclock run, with the main oscillator off and the monitor at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| sub_tick | input | 1 | One pulse per subclock-referenced tick, advances the stabilization countdown |
| reg_wr_en | input | 1 | Control register write strobe |
| reg_wr_data | input | 5 | Write data: bit 0 source select, bits 2:1 gear, bits 4:3 wait select |
| reg_rd_data | output | 8 | Readback: control fields plus monitor in bit 7 |
| standby_req | input | 1 | Standby request pulse |
| standby_kind | input | 2 | Requested standby kind: 00 sleep, 01 stop, 10 watch, 11 sleep |
| wake | input | 1 | Leave the current standby state |
| gear_sel | output | 2 | Main clock speed gear for the downstream divider |
| clk_src_main | output | 1 | 1 while the main clock drives the system |
| main_osc_en | output | 1 | Main oscillator enable |
| sub_osc_en | output | 1 | Subclock oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| periph_clk_en | output | 1 | Peripheral clock enable |
| tbt_clk_en | output | 1 | Timebase timer clock enable |

## Verification
Register fields and gear_sel are due one edge after the write strobe. A change of source select acts on the mode and the enables one further edge later. The monitor rises on the very edge that takes in the final counted tick. Standby and wake act on the next edge. The bench drives every input on the falling edge. A behavioural model is updated on each rising edge from the inputs it saw, and every output is compared with that model on the following falling edge, so each result is sampled one full register stage after its cause. Directed checks count falling edges from the write strobe to the monitor rise and expect exactly the wait length plus the one edge that loads the counter.

// File: rtl/cmc_pkg.sv
package cmc_pkg;

    localparam int WR_W = 5;
    localparam int RD_W = 8;

    typedef enum logic [2:0] {
        ST_MAIN_RUN,
        ST_SUB_RUN,
        ST_WAIT_MAIN,
        ST_MAIN_SLEEP,
        ST_MAIN_STOP,
        ST_SUB_SLEEP,
        ST_SUB_STOP,
        ST_WATCH
    } cmc_state_e;

    localparam logic [1:0] SB_SLEEP = 2'b00;
    localparam logic [1:0] SB_STOP  = 2'b01;
    localparam logic [1:0] SB_WATCH = 2'b10;

    typedef struct packed {
        logic       sel;
        logic [1:0] speed;
        logic [1:0] wsel;
    } cmc_regs_t;

    typedef struct packed {
        cmc_state_e state;
        logic       mon;
    } cmc_fsm_t;

endpackage

// File: rtl/cmc_stab_counter.sv
module cmc_stab_counter #(
    parameter int LOG_A = 12,
    parameter int LOG_B = 14,
    parameter int LOG_C = 16
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       load_i,
    input  logic [1:0] wsel_i,
    input  logic       tick_i,
    output logic       expire_o
);
    localparam int CNT_W = LOG_C + 1;
    localparam logic [CNT_W-1:0] LEN_A = CNT_W'(1) << LOG_A;
    localparam logic [CNT_W-1:0] LEN_B = CNT_W'(1) << LOG_B;
    localparam logic [CNT_W-1:0] LEN_C = CNT_W'(1) << LOG_C;

    logic [CNT_W-1:0] cnt_d, cnt_q, len;

    always_comb begin
        case (wsel_i)
            2'b10:   len = LEN_B;
            2'b11:   len = LEN_C;
            default: len = LEN_A;
        endcase
    end

    assign expire_o = tick_i && (cnt_q == CNT_W'(1));

    always_comb begin
        cnt_d = cnt_q;
        if (load_i) begin
            cnt_d = len;
        end else if (tick_i && (cnt_q != '0)) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= LEN_A;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    AST_CNT_HOLDS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!load_i && !tick_i) |=> $stable(cnt_q)); // R5

endmodule

// File: rtl/cmc_mode_fsm.sv
module cmc_mode_fsm
    import cmc_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       sel_i,
    input  logic       standby_req_i,
    input  logic [1:0] standby_kind_i,
    input  logic       wake_i,
    input  logic       expire_i,
    output cmc_state_e state_o,
    output logic       mon_o,
    output logic       load_o,
    output logic       count_en_o
);
    cmc_fsm_t fsm_d, fsm_q;

    always_comb begin
        fsm_d  = fsm_q;
        load_o = 1'b0;
        case (fsm_q.state)
            ST_MAIN_RUN: begin
                if (!sel_i) begin
                    fsm_d.state = ST_SUB_RUN;
                    fsm_d.mon   = 1'b0;
                end else if (standby_req_i) begin
                    if (standby_kind_i == SB_STOP || standby_kind_i == SB_WATCH) begin
                        fsm_d.state = ST_MAIN_STOP;
                    end else begin
                        fsm_d.state = ST_MAIN_SLEEP;
                    end
                end
            end
            ST_SUB_RUN: begin
                if (sel_i) begin
                    fsm_d.state = ST_WAIT_MAIN;
                    load_o      = 1'b1;
                end else if (standby_req_i) begin
                    case (standby_kind_i)
                        SB_STOP:  fsm_d.state = ST_SUB_STOP;
                        SB_WATCH: fsm_d.state = ST_WATCH;
                        default:  fsm_d.state = ST_SUB_SLEEP;
                    endcase
                end
            end
            ST_WAIT_MAIN: begin
                if (!sel_i) begin
                    fsm_d.state = ST_SUB_RUN;
                end else if (expire_i) begin
                    fsm_d.state = ST_MAIN_RUN;
                    fsm_d.mon   = 1'b1;
                end
            end
            ST_MAIN_SLEEP: begin
                if (wake_i) fsm_d.state = ST_MAIN_RUN;
            end
            ST_MAIN_STOP: begin
                if (wake_i) begin
                    fsm_d.state = ST_WAIT_MAIN;
                    fsm_d.mon   = 1'b0;
                    load_o      = 1'b1;
                end
            end
            default: begin
                if (wake_i) fsm_d.state = ST_SUB_RUN;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fsm_q.state <= ST_WAIT_MAIN;
            fsm_q.mon   <= 1'b0;
        end else begin
            fsm_q <= fsm_d;
        end
    end

    assign state_o    = fsm_q.state;
    assign mon_o      = fsm_q.mon;
    assign count_en_o = (fsm_q.state == ST_WAIT_MAIN);

    AST_MON_RISE_ON_EXPIRE: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.mon && !$past(fsm_q.mon)) |-> $past(expire_i)); // R5

    AST_DESEL_DROPS_MON: assert property (@(posedge clk) disable iff (!rst_n)
        (fsm_q.state == ST_MAIN_RUN && !sel_i) |=> !fsm_q.mon); // R3

endmodule

// File: rtl/cmc_enable_decode.sv
module cmc_enable_decode
    import cmc_pkg::*;
(
    input  cmc_state_e state_i,
    output logic       main_osc_en_o,
    output logic       sub_osc_en_o,
    output logic       cpu_clk_en_o,
    output logic       periph_clk_en_o,
    output logic       tbt_clk_en_o
);
    always_comb begin
        main_osc_en_o   = 1'b0;
        sub_osc_en_o    = 1'b1;
        cpu_clk_en_o    = 1'b0;
        periph_clk_en_o = 1'b0;
        tbt_clk_en_o    = 1'b0;
        case (state_i)
            ST_MAIN_RUN: begin
                main_osc_en_o   = 1'b1;
                cpu_clk_en_o    = 1'b1;
                periph_clk_en_o = 1'b1;
                tbt_clk_en_o    = 1'b1;
            end
            ST_MAIN_SLEEP: begin
                main_osc_en_o   = 1'b1;
                periph_clk_en_o = 1'b1;
                tbt_clk_en_o    = 1'b1;
            end
            ST_WAIT_MAIN: begin
                main_osc_en_o   = 1'b1;
                cpu_clk_en_o    = 1'b1;
                periph_clk_en_o = 1'b1;
            end
            ST_SUB_RUN: begin
                cpu_clk_en_o    = 1'b1;
                periph_clk_en_o = 1'b1;
            end
            ST_SUB_SLEEP: begin
                periph_clk_en_o = 1'b1;
            end
            ST_SUB_STOP: begin
                sub_osc_en_o    = 1'b0;
            end
            default: begin
            end
        endcase
    end
endmodule

// File: rtl/sysclk_mode_ctrl.sv
module sysclk_mode_ctrl
    import cmc_pkg::*;
#(
    parameter int WAIT_LOG_A = 12,
    parameter int WAIT_LOG_B = 14,
    parameter int WAIT_LOG_C = 16
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sub_tick,
    input  logic            reg_wr_en,
    input  logic [WR_W-1:0] reg_wr_data,
    output logic [RD_W-1:0] reg_rd_data,
    input  logic            standby_req,
    input  logic [1:0]      standby_kind,
    input  logic            wake,
    output logic [1:0]      gear_sel,
    output logic            clk_src_main,
    output logic            main_osc_en,
    output logic            sub_osc_en,
    output logic            cpu_clk_en,
    output logic            periph_clk_en,
    output logic            tbt_clk_en
);
    cmc_regs_t  regs_d, regs_q;
    cmc_state_e state;
    logic       mon, load, count_en, expire;

    always_comb begin
        regs_d = regs_q;
        if (reg_wr_en) begin
            regs_d.sel   = reg_wr_data[0];
            regs_d.speed = reg_wr_data[2:1];
            if (mon) regs_d.wsel = reg_wr_data[4:3];
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            regs_q.sel   <= 1'b1;
            regs_q.speed <= 2'b00;
            regs_q.wsel  <= 2'b00;
        end else begin
            regs_q <= regs_d;
        end
    end

    cmc_mode_fsm u_fsm (
        .clk            (clk),
        .rst_n          (rst_n),
        .sel_i          (regs_q.sel),
        .standby_req_i  (standby_req),
        .standby_kind_i (standby_kind),
        .wake_i         (wake),
        .expire_i       (expire),
        .state_o        (state),
        .mon_o          (mon),
        .load_o         (load),
        .count_en_o     (count_en)
    );

    cmc_stab_counter #(
        .LOG_A (WAIT_LOG_A),
        .LOG_B (WAIT_LOG_B),
        .LOG_C (WAIT_LOG_C)
    ) u_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load_i   (load),
        .wsel_i   (regs_q.wsel),
        .tick_i   (count_en && sub_tick),
        .expire_o (expire)
    );

    cmc_enable_decode u_dec (
        .state_i         (state),
        .main_osc_en_o   (main_osc_en),
        .sub_osc_en_o    (sub_osc_en),
        .cpu_clk_en_o    (cpu_clk_en),
        .periph_clk_en_o (periph_clk_en),
        .tbt_clk_en_o    (tbt_clk_en)
    );

    assign reg_rd_data  = {mon, 2'b00, regs_q.wsel, regs_q.speed, regs_q.sel};
    assign gear_sel     = regs_q.speed;
    assign clk_src_main = mon;

    AST_WAIT_FIELD_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        !mon |=> $stable(regs_q.wsel)); // R6

    AST_TBT_ONLY_ON_MAIN: assert property (@(posedge clk) disable iff (!rst_n)
        tbt_clk_en |-> (clk_src_main && main_osc_en)); // R10

    AST_EXPIRE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        expire |=> !expire); // R5

endmodule

// File: tb/sysclk_mode_ctrl_tb_top.sv
module sysclk_mode_ctrl_tb_top;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       sub_tick = 1'b0;
    logic       wr_en = 1'b0;
    logic [4:0] wr_data = '0;
    logic [7:0] rd_data;
    logic       sb_req = 1'b0;
    logic [1:0] sb_kind = '0;
    logic       wake = 1'b0;
    logic [1:0] gear;
    logic       src_main, mosc, sosc, cpu_en, per_en, tbt_en;

    always #10 clk = ~clk;

    sysclk_mode_ctrl dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .sub_tick      (sub_tick),
        .reg_wr_en     (wr_en),
        .reg_wr_data   (wr_data),
        .reg_rd_data   (rd_data),
        .standby_req   (sb_req),
        .standby_kind  (sb_kind),
        .wake          (wake),
        .gear_sel      (gear),
        .clk_src_main  (src_main),
        .main_osc_en   (mosc),
        .sub_osc_en    (sosc),
        .cpu_clk_en    (cpu_en),
        .periph_clk_en (per_en),
        .tbt_clk_en    (tbt_en)
    );

    int    n_chk = 0;
    int    n_err = 0;
    string phase = "R1";
    bit    tick_every = 1'b1;
    bit    done = 1'b0;

    localparam int M_MRUN = 0, M_SRUN = 1, M_WAIT = 2, M_MSLP = 3,
                   M_MSTP = 4, M_SSLP = 5, M_SSTP = 6, M_WTCH = 7;

    int       m_mode, m_cnt;
    bit       m_sel, m_mon;
    bit [1:0] m_spd, m_wt;

    function automatic int wlen(bit [1:0] w);
        if (w == 2'b10) return 16384;
        if (w == 2'b11) return 65536;
        return 4096;
    endfunction

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_mode = M_WAIT; m_cnt = 4096; m_sel = 1'b1; m_mon = 1'b0;
            m_spd = 2'b00; m_wt = 2'b00;
        end else begin : upd
            int       nm, nc;
            bit       nsel, nmon;
            bit [1:0] nspd, nwt;
            nm = m_mode; nc = m_cnt; nsel = m_sel; nmon = m_mon; nspd = m_spd; nwt = m_wt;
            if (wr_en) begin
                nsel = wr_data[0];
                nspd = wr_data[2:1];
                if (m_mon) nwt = wr_data[4:3];
            end
            case (m_mode)
                M_MRUN: if (!m_sel) begin nm = M_SRUN; nmon = 1'b0; end
                        else if (sb_req) nm = (sb_kind == 2'b01 || sb_kind == 2'b10) ? M_MSTP : M_MSLP;
                M_SRUN: if (m_sel) begin nm = M_WAIT; nc = wlen(m_wt); end
                        else if (sb_req) nm = (sb_kind == 2'b01) ? M_SSTP : (sb_kind == 2'b10) ? M_WTCH : M_SSLP;
                M_WAIT: if (!m_sel) nm = M_SRUN;
                        else if (sub_tick) begin
                            nc = m_cnt - 1;
                            if (nc == 0) begin nm = M_MRUN; nmon = 1'b1; end
                        end
                M_MSLP: if (wake) nm = M_MRUN;
                M_MSTP: if (wake) begin nm = M_WAIT; nmon = 1'b0; nc = wlen(m_wt); end
                default: if (wake) nm = M_SRUN;
            endcase
            m_mode = nm; m_cnt = nc; m_sel = nsel; m_mon = nmon; m_spd = nspd; m_wt = nwt;
        end
    end

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp, string what);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s %s actual=%h expected=%h at %0t", tag, what, act, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (rst_n && !done) begin : cmp
            logic [15:0] exp_v, act_v;
            bit e_mo, e_cpu, e_per, e_tbt, e_so;
            e_mo  = (m_mode == M_MRUN || m_mode == M_WAIT || m_mode == M_MSLP);
            e_so  = (m_mode != M_SSTP);
            e_cpu = (m_mode == M_MRUN || m_mode == M_SRUN || m_mode == M_WAIT);
            e_per = e_cpu || m_mode == M_MSLP || m_mode == M_SSLP;
            e_tbt = (m_mode == M_MRUN || m_mode == M_MSLP);
            exp_v = {m_mon, 2'b00, m_wt, m_spd, m_sel, m_mon, e_mo, e_so, e_cpu, e_per, e_tbt, m_spd};
            act_v = {rd_data, src_main, mosc, sosc, cpu_en, per_en, tbt_en, gear};
            chk(phase, 32'(act_v), 32'(exp_v), "model compare");
        end
        sub_tick <= tick_every ? 1'b1 : ~sub_tick;
    end

    task automatic finish_run();
        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", n_err, n_chk);
        $finish;
    endtask

    task automatic wr(input logic [4:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic stby(input logic [1:0] k);
        @(negedge clk); sb_req = 1'b1; sb_kind = k;
        @(negedge clk); sb_req = 1'b0;
    endtask

    task automatic wk();
        @(negedge clk); wake = 1'b1;
        @(negedge clk); wake = 1'b0;
    endtask

    task automatic wait_mon(input int limit, output int n);
        n = 0;
        while (src_main !== 1'b1 && n < limit) begin
            @(negedge clk); n++;
        end
    endtask

    initial begin
        repeat (190000) @(posedge clk);
        n_err++; n_chk++;
        $display("FAIL R1 watchdog expired actual=hung expected=done");
        finish_run();
    end

    initial begin
        int n;
        repeat (3) @(negedge clk);
        chk("R1", 32'(rd_data), 32'h01, "readback in reset");
        chk("R1", 32'({mosc, sosc, cpu_en}), 32'b111, "enables in reset");
        rst_n = 1'b1;
        phase = "R5";
        wait_mon(5000, n);
        chk("R5", 32'(n), 32'd4096, "reset wait length, select 00");

        phase = "R2";
        wr(5'b00011); chk("R2", 32'(gear), 32'd1, "gear 01");
        wr(5'b00101); chk("R2", 32'(gear), 32'd2, "gear 10");
        wr(5'b00111); chk("R2", 32'(gear), 32'd3, "gear 11");
        phase = "R6";
        wr(5'b01011); chk("R6", 32'(rd_data), 32'h8B, "wait select written on main");
        chk("R10", 32'(tbt_en), 32'd1, "timebase on in main run");

        phase = "R7";
        stby(2'b00);
        chk("R7", 32'({cpu_en, per_en, mosc, tbt_en}), 32'b0111, "main sleep");
        phase = "R9"; wk();
        chk("R9", 32'(cpu_en), 32'd1, "wake from main sleep");
        phase = "R7";
        stby(2'b10);
        chk("R7", 32'({cpu_en, per_en, mosc, sosc, tbt_en}), 32'b00010, "main stop");
        phase = "R9"; wk();
        chk("R9", 32'({src_main, mosc, cpu_en}), 32'b011, "main stop wake enters wait");
        wait_mon(10000, n);
        chk("R9", 32'(n), 32'd4096, "wait length after main stop");

        phase = "R3";
        wr(5'b01010);
        chk("R3", 32'({rd_data[0], src_main}), 32'b01, "select cleared, monitor lags");
        @(negedge clk);
        chk("R3", 32'({src_main, mosc}), 32'b00, "monitor and main osc off");
        chk("R10", 32'(tbt_en), 32'd0, "timebase off on subclock");

        phase = "R6";
        wr(5'b11010);
        chk("R6", 32'(rd_data), 32'h0A, "wait select ignored on subclock");

        phase = "R8";
        stby(2'b00);
        chk("R8", 32'({cpu_en, per_en, sosc}), 32'b011, "sub sleep");
        wk();
        stby(2'b01);
        chk("R8", 32'({cpu_en, per_en, sosc}), 32'b000, "sub stop");
        wk();
        stby(2'b10);
        chk("R8", 32'({cpu_en, per_en, sosc, mosc}), 32'b0010, "watch");
        phase = "R9"; wk();
        chk("R9", 32'({cpu_en, mosc}), 32'b10, "wake to sub run");

        phase = "R4";
        wr(5'b01011);
        @(negedge clk);
        chk("R4", 32'({mosc, src_main, cpu_en}), 32'b101, "main osc on, monitor still sub");
        repeat (100) @(negedge clk);
        phase = "R11";
        wr(5'b01010);
        @(negedge clk);
        chk("R11", 32'({mosc, src_main, cpu_en}), 32'b001, "wait abandoned");

        phase = "R5";
        tick_every = 1'b0;
        wr(5'b01011);
        wait_mon(20000, n);
        chk("R5", 32'(n >= 8190 && n <= 8196), 32'd1, "half-rate ticks double the wait");
        tick_every = 1'b1;
        @(negedge clk);

        wr(5'b10011);
        wr(5'b10010);
        @(negedge clk);
        wr(5'b10011);
        wait_mon(20000, n);
        chk("R5", 32'(n), 32'd16385, "wait select 10");

        wr(5'b11011);
        wr(5'b11010);
        @(negedge clk);
        wr(5'b11011);
        wait_mon(70000, n);
        chk("R5", 32'(n), 32'd65537, "wait select 11");

        repeat (3) @(negedge clk);
        finish_run();
    end

endmodule